// File: doc/BRIEF.md
# Dual-Channel UART Register Port

This block is the processor-facing register access unit of a two-channel UART slice. A host reaches it over an 8-bit data path with a 6-bit address and three active-low controls: a chip select, a read strobe and a write strobe. The controls arrive asynchronously. They are brought into the system clock domain, and each strobe becomes a single internal event. A write is committed when its strobe is released. A read captures the selected register when the strobe is first asserted and presents that value for as long as the read stays active.

Each channel has two mode registers behind one address. A per-channel pointer chooses which one is reached. After reset the pointer selects the first mode register. The first access of either kind moves the pointer to the second register, and it stays there until reset or a pointer-return command written to that channel's command register. The serial engines are not part of this block. Their clock-select and data registers, plus two block-level registers, are plain read/write storage here.

Top module: `duo_uart_regport`

## Requirements
- R1: After reset every stored register reads 0x00, both pointers select the first mode register, `rdata_oe` is low and `rdata` is 0x00.
- R2: `rdata_oe` is high only while a read is active (`cs_n` and `rd_n` both low) and drops within three clock cycles of either going high. While `rdata_oe` is low, `rdata` is 0x00. A low `rd_n` with `cs_n` high never drives the bus.
- R3: A write commits when the write strobe or chip select is released after both were low. Write-strobe activity while `cs_n` is high changes nothing.
- R4: Address map (channel 0 at 0x00, channel 1 at 0x08): offset 0 is the shared mode address, offset 1 is clock select (read/write), offset 2 is the command register (write-only, reads 0x00), offset 3 is the data register (read/write). 0x10 is the auxiliary control register and 0x11 is the interrupt mask, both read/write. A read returns the value captured at read start.
- R5: A read or write to a channel's mode address while its pointer selects the first mode register reaches the first mode register, and the pointer then moves to the second.
- R6: While the pointer selects the second mode register, every mode access of that channel reaches the second register and the pointer stays there.
- R7: Writing a command byte whose upper nibble (bits 7:4) is 0001 to a channel's command register returns that channel's pointer to the first mode register. Other upper-nibble codes leave the pointer unchanged.
- R8: The two channels' pointers and mode registers are independent. Access to one channel never moves the other channel's pointer.
- R9: Addresses outside the map read 0x00, and writes to them change no register.
- R10: A strobe held low for many cycles counts as exactly one access, so it moves the pointer at most once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| cs_n | input | 1 | Chip select, active low, asynchronous |
| rd_n | input | 1 | Read strobe, active low, asynchronous |
| wr_n | input | 1 | Write strobe, active low, asynchronous |
| addr | input | 6 | Register address, held stable during a strobe |
| wdata | input | 8 | Write data, held stable until the write strobe is released |
| rdata | output | 8 | Read data, 0x00 when not driving |
| rdata_oe | output | 1 | Bus drive enable for an external tri-state buffer |

## Verification
A pointer stuck at either mode register, or advanced twice by one long strobe, appears at the ports on the next read of that mode address. That read returns the other register's contents, so the fault is visible within one bus cycle. A pointer that ignores the return command, or answers to the wrong channel, shows up the same way on the first mode read after the command. A bad address decode or a write accepted without chip select corrupts a stored value, and the corruption appears when that address is next read. A stuck drive enable is seen on the first idle sample after a read ends.

// File: rtl/regif_pkg.sv
package regif_pkg;

  localparam int ADDR_W    = 6;
  localparam int DATA_W    = 8;
  localparam int CH_N      = 2;
  localparam int CH_W      = (CH_N > 1) ? $clog2(CH_N) : 1;
  localparam int OFF_W     = 3;                 // offsets within one channel window
  localparam int CH_STRIDE = 1 << OFF_W;
  localparam int CH_SPAN   = CH_N * CH_STRIDE;
  localparam int NUM_CTL   = 3;                 // cs, rd, wr

  localparam logic [OFF_W-1:0]  OFF_MODE = 3'd0;
  localparam logic [OFF_W-1:0]  OFF_CLK  = 3'd1;
  localparam logic [OFF_W-1:0]  OFF_CMD  = 3'd2;
  localparam logic [OFF_W-1:0]  OFF_DATA = 3'd3;
  localparam logic [ADDR_W-1:0] ADR_AUX  = 6'h10;
  localparam logic [ADDR_W-1:0] ADR_MASK = 6'h11;

  localparam logic [3:0] CMD_PTR_HOME = 4'h1;

  typedef enum logic [2:0] {
    SEL_NONE, SEL_MODE, SEL_CLK, SEL_CMD, SEL_DATA, SEL_AUX, SEL_MASK
  } sel_e;

  typedef struct packed {
    sel_e             kind;
    logic [CH_W-1:0]  ch;
  } dec_t;

  // Address decode shared by the read and the write side.
  function automatic dec_t decode_addr(input logic [ADDR_W-1:0] a);
    dec_t d;
    d.kind = SEL_NONE;
    d.ch   = CH_W'(a >> OFF_W);
    if (int'(a) < CH_SPAN) begin
      case (a[OFF_W-1:0])
        OFF_MODE: d.kind = SEL_MODE;
        OFF_CLK:  d.kind = SEL_CLK;
        OFF_CMD:  d.kind = SEL_CMD;
        OFF_DATA: d.kind = SEL_DATA;
        default:  d.kind = SEL_NONE;
      endcase
    end else if (a == ADR_AUX) begin
      d.kind = SEL_AUX;
    end else if (a == ADR_MASK) begin
      d.kind = SEL_MASK;
    end
    return d;
  endfunction

  // Upper command nibble selects the pointer-return action.
  function automatic logic is_ptr_home(input logic [DATA_W-1:0] cmd);
    return cmd[DATA_W-1 -: 4] == CMD_PTR_HOME;
  endfunction

endpackage

// File: rtl/regif_sync.sv
module regif_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic async_in,
  output logic level
);
  // Inactive (high) reset value so no strobe event appears out of reset.
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk) begin
    if (rst) chain_q <= '1;
    else     chain_q <= {chain_q[STAGES-2:0], async_in};
  end

  assign level = chain_q[STAGES-1];
endmodule

// File: rtl/regif_mode_ptr.sv
module regif_mode_ptr (
  input  logic clk,
  input  logic rst,
  input  logic go_home,
  input  logic access,
  output logic at_second
);
  always_ff @(posedge clk) begin
    if (rst)          at_second <= 1'b0;
    else if (go_home) at_second <= 1'b0;
    else if (access)  at_second <= 1'b1;
  end

  // R5: an access moves the pointer to the second mode register
  p_advance_r5: assert property (@(posedge clk) disable iff (rst)
    access && !go_home |=> at_second);

  // R6: once at the second register the pointer only leaves on a command
  p_sticky_r6: assert property (@(posedge clk) disable iff (rst)
    at_second && !go_home |=> at_second);

  // R7: the return command always lands on the first register
  p_home_r7: assert property (@(posedge clk) disable iff (rst)
    go_home |=> !at_second);
endmodule

// File: rtl/regif_regs.sv
module regif_regs
  import regif_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_fire,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [CH_N-1:0]   ptr_second,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [DATA_W-1:0] rd_val
);
  logic [DATA_W-1:0] mode1_q [CH_N];
  logic [DATA_W-1:0] mode2_q [CH_N];
  logic [DATA_W-1:0] clks_q  [CH_N];
  logic [DATA_W-1:0] data_q  [CH_N];
  logic [DATA_W-1:0] aux_q, mask_q;

  dec_t wdec, rdec;
  assign wdec = decode_addr(wr_addr);
  assign rdec = decode_addr(rd_addr);

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int c = 0; c < CH_N; c++) begin
        mode1_q[c] <= '0;
        mode2_q[c] <= '0;
        clks_q[c]  <= '0;
        data_q[c]  <= '0;
      end
      aux_q  <= '0;
      mask_q <= '0;
    end else if (wr_fire) begin
      for (int c = 0; c < CH_N; c++) begin
        if (wdec.ch == CH_W'(c)) begin
          case (wdec.kind)
            SEL_MODE: if (ptr_second[c]) mode2_q[c] <= wr_data;
                      else               mode1_q[c] <= wr_data;
            SEL_CLK:  clks_q[c] <= wr_data;
            SEL_DATA: data_q[c] <= wr_data;
            default:  ;
          endcase
        end
      end
      if (wdec.kind == SEL_AUX)  aux_q  <= wr_data;
      if (wdec.kind == SEL_MASK) mask_q <= wr_data;
    end
  end

  always_comb begin
    rd_val = '0;
    case (rdec.kind)
      SEL_MODE: rd_val = ptr_second[rdec.ch] ? mode2_q[rdec.ch] : mode1_q[rdec.ch];
      SEL_CLK:  rd_val = clks_q[rdec.ch];
      SEL_DATA: rd_val = data_q[rdec.ch];
      SEL_AUX:  rd_val = aux_q;
      SEL_MASK: rd_val = mask_q;
      default:  rd_val = '0;   // command register and holes read zero
    endcase
  end

  // R9: a write to a hole leaves the block-level registers untouched
  p_hole_write_ignored_r9: assert property (@(posedge clk) disable iff (rst)
    wr_fire && wdec.kind == SEL_NONE |=> $stable(aux_q) && $stable(mask_q));
endmodule

// File: rtl/duo_uart_regport.sv
module duo_uart_regport
  import regif_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cs_n,
  input  logic              rd_n,
  input  logic              wr_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output logic              rdata_oe
);
  localparam int IX_WR = 0;
  localparam int IX_RD = 1;
  localparam int IX_CS = 2;

  // ---- strobe synchronisation ----
  logic [NUM_CTL-1:0] ctl_raw, ctl_lvl;
  assign ctl_raw = {cs_n, rd_n, wr_n};

  for (genvar i = 0; i < NUM_CTL; i++) begin : g_sync
    regif_sync #(.STAGES(SYNC_STAGES)) sync_i (
      .clk(clk), .rst(rst), .async_in(ctl_raw[i]), .level(ctl_lvl[i])
    );
  end

  // ---- access events: one pulse per strobe ----
  logic rd_act, rd_act_q, wr_act, wr_act_q;
  logic rd_start, wr_fire;

  assign rd_act   = !ctl_lvl[IX_RD] && !ctl_lvl[IX_CS];
  assign wr_act   = !ctl_lvl[IX_WR] && !ctl_lvl[IX_CS];
  assign rd_start = rd_act && !rd_act_q;     // leading edge of a read
  assign wr_fire  = !wr_act && wr_act_q;     // trailing edge of a write

  logic [ADDR_W-1:0] wa_q;
  logic [DATA_W-1:0] wd_q;
  logic [DATA_W-1:0] rd_hold_q;
  logic [DATA_W-1:0] rd_val;

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_act_q <= 1'b0;
      wr_act_q <= 1'b0;
      wa_q     <= '0;
      wd_q     <= '0;
    end else begin
      rd_act_q <= rd_act;
      wr_act_q <= wr_act;
      if (wr_act) begin
        wa_q <= addr;
        wd_q <= wdata;
      end
    end
  end

  // ---- mode pointers, one per channel ----
  dec_t wdec, rdec;
  assign wdec = decode_addr(wa_q);
  assign rdec = decode_addr(addr);

  logic [CH_N-1:0] ptr_second, ptr_home, ptr_access;

  for (genvar c = 0; c < CH_N; c++) begin : g_ptr
    assign ptr_home[c]   = wr_fire && wdec.kind == SEL_CMD && wdec.ch == CH_W'(c)
                           && is_ptr_home(wd_q);
    assign ptr_access[c] = (wr_fire  && wdec.kind == SEL_MODE && wdec.ch == CH_W'(c))
                        || (rd_start && rdec.kind == SEL_MODE && rdec.ch == CH_W'(c));
    regif_mode_ptr ptr_i (
      .clk(clk), .rst(rst), .go_home(ptr_home[c]),
      .access(ptr_access[c]), .at_second(ptr_second[c])
    );
  end

  // ---- register storage ----
  regif_regs regs_i (
    .clk(clk), .rst(rst), .wr_fire(wr_fire), .wr_addr(wa_q), .wr_data(wd_q),
    .ptr_second(ptr_second), .rd_addr(addr), .rd_val(rd_val)
  );

  // ---- read data capture ----
  always_ff @(posedge clk) begin
    if (rst)           rd_hold_q <= '0;
    else if (rd_start) rd_hold_q <= rd_val;
  end

  assign rdata_oe = rd_act_q;
  assign rdata    = rd_act_q ? rd_hold_q : '0;

  // R2: releasing the strobe or the select ends the drive on the next edge
  p_oe_release_r2: assert property (@(posedge clk) disable iff (rst)
    ctl_lvl[IX_RD] || ctl_lvl[IX_CS] |=> !rdata_oe);

  // R10: each read and each write produces a single event
  p_one_read_r10: assert property (@(posedge clk) disable iff (rst)
    rd_start |=> !rd_start);
  p_one_write_r10: assert property (@(posedge clk) disable iff (rst)
    wr_fire |=> !wr_fire);

  // R9: a hole read presents zero
  p_hole_read_zero_r9: assert property (@(posedge clk) disable iff (rst)
    rd_start && rdec.kind == SEL_NONE |=> rdata == '0);

  // R3: no write event without a selected write strobe in the previous cycle
  p_write_needs_select_r3: assert property (@(posedge clk) disable iff (rst)
    wr_fire |-> $past(!ctl_lvl[IX_CS] && !ctl_lvl[IX_WR]));
endmodule

// File: tb/duo_uart_regport_tb_top.sv
module duo_uart_regport_tb_top;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       cs_n = 1'b1, rd_n = 1'b1, wr_n = 1'b1;
  logic [5:0] addr = '0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata;
  logic       rdata_oe;

  int total = 0;
  int bad   = 0;
  bit done  = 1'b0;

  always #2 clk = ~clk;   // 250 MHz

  duo_uart_regport dut_i (
    .clk(clk), .rst(rst), .cs_n(cs_n), .rd_n(rd_n), .wr_n(wr_n),
    .addr(addr), .wdata(wdata), .rdata(rdata), .rdata_oe(rdata_oe)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_write(input logic [5:0] a, input logic [7:0] d,
                           input bit sel, input int hold);
    @(negedge clk);
    addr = a; wdata = d; cs_n = !sel; wr_n = 1'b0;
    idle(hold);
    wr_n = 1'b1;
    idle(4);
    cs_n = 1'b1;
    idle(2);
  endtask

  task automatic bus_read(input logic [5:0] a, input bit sel, input int hold,
                          output logic [7:0] d, output logic oe);
    @(negedge clk);
    addr = a; cs_n = !sel; rd_n = 1'b0;
    idle(hold);
    d = rdata; oe = rdata_oe;
    rd_n = 1'b1; cs_n = 1'b1;
    idle(4);
  endtask

  task automatic expect_read(input logic [5:0] a, input logic [7:0] exp, input string req);
    logic [7:0] d; logic oe;
    bus_read(a, 1'b1, 5, d, oe);
    check(oe === 1'b1, {req, " oe during read"}, oe, 1);
    check(d === exp, req, d, exp);
    check(rdata_oe === 1'b0 && rdata === 8'h00, "R2 bus idle after read", rdata, 0);
  endtask

  task automatic t_reset;
    check(rdata_oe === 1'b0, "R1 oe at reset", rdata_oe, 0);
    check(rdata === 8'h00, "R1 rdata at reset", rdata, 0);
    expect_read(6'h00, 8'h00, "R1 mode ch0");
    expect_read(6'h09, 8'h00, "R1 clksel ch1");
    expect_read(6'h10, 8'h00, "R1 aux");
    expect_read(6'h11, 8'h00, "R1 mask");
  endtask

  task automatic t_mode_sequence;
    // pointer of ch0 already at second after R1 read; return it first
    bus_write(6'h02, 8'h10, 1'b1, 4);
    bus_write(6'h00, 8'h11, 1'b1, 4);          // first mode register
    bus_write(6'h00, 8'h22, 1'b1, 4);          // second mode register
    expect_read(6'h00, 8'h22, "R5 write advanced pointer");
    expect_read(6'h00, 8'h22, "R6 pointer stays at second");
  endtask

  task automatic t_command;
    bus_write(6'h02, 8'h10, 1'b1, 4);
    expect_read(6'h00, 8'h11, "R7 home command then first");
    expect_read(6'h00, 8'h22, "R5 read advanced pointer");
    bus_write(6'h02, 8'h20, 1'b1, 4);
    expect_read(6'h00, 8'h22, "R7 other code keeps pointer");
    bus_write(6'h02, 8'h1F, 1'b1, 4);
    expect_read(6'h00, 8'h11, "R7 lower nibble ignored");
    expect_read(6'h02, 8'h00, "R4 command reads zero");
  endtask

  task automatic t_channels;
    // ch0 pointer now at second; ch1 pointer at first since reset
    bus_write(6'h08, 8'h33, 1'b1, 4);
    expect_read(6'h08, 8'h00, "R8 ch1 second register");
    expect_read(6'h00, 8'h22, "R8 ch0 unaffected by ch1");
    bus_write(6'h0A, 8'h10, 1'b1, 4);
    expect_read(6'h00, 8'h22, "R8 ch1 command leaves ch0");
    expect_read(6'h08, 8'h33, "R8 ch1 returned to first");
  endtask

  task automatic t_plain_regs;
    bus_write(6'h03, 8'h5A, 1'b1, 4);
    bus_write(6'h0B, 8'hA5, 1'b1, 4);
    bus_write(6'h01, 8'h77, 1'b1, 4);
    bus_write(6'h10, 8'h3C, 1'b1, 4);
    bus_write(6'h11, 8'hC3, 1'b1, 4);
    expect_read(6'h03, 8'h5A, "R4 data ch0");
    expect_read(6'h0B, 8'hA5, "R4 data ch1");
    expect_read(6'h01, 8'h77, "R4 clksel ch0");
    expect_read(6'h09, 8'h00, "R4 clksel ch1");
    expect_read(6'h10, 8'h3C, "R4 aux");
    expect_read(6'h11, 8'hC3, "R4 mask");
  endtask

  task automatic t_long_strobes;
    logic [7:0] d; logic oe;
    bus_write(6'h02, 8'h10, 1'b1, 4);
    bus_write(6'h00, 8'h44, 1'b1, 30);         // one long write: first register
    expect_read(6'h00, 8'h22, "R10 long write moved pointer once");
    bus_write(6'h02, 8'h10, 1'b1, 4);
    bus_read(6'h00, 1'b1, 30, d, oe);
    check(d === 8'h44, "R10 long read first register", d, 8'h44);
    check(oe === 1'b1, "R2 oe held through long read", oe, 1);
    expect_read(6'h00, 8'h22, "R10 long read moved pointer once");
  endtask

  task automatic t_select_gate;
    logic [7:0] d; logic oe;
    bus_write(6'h03, 8'hEE, 1'b0, 4);          // no chip select
    expect_read(6'h03, 8'h5A, "R3 write without select ignored");
    bus_write(6'h02, 8'h10, 1'b1, 4);
    bus_read(6'h00, 1'b0, 6, d, oe);           // read strobe without select
    check(oe === 1'b0, "R2 no drive without select", oe, 0);
    check(d === 8'h00, "R2 rdata zero without select", d, 0);
    expect_read(6'h00, 8'h44, "R3 unselected read left pointer");
  endtask

  task automatic t_holes;
    bus_write(6'h05, 8'h99, 1'b1, 4);
    bus_write(6'h3F, 8'h99, 1'b1, 4);
    bus_write(6'h12, 8'h99, 1'b1, 4);
    expect_read(6'h05, 8'h00, "R9 hole 0x05");
    expect_read(6'h3F, 8'h00, "R9 hole 0x3F");
    expect_read(6'h12, 8'h00, "R9 hole 0x12");
    expect_read(6'h10, 8'h3C, "R9 aux untouched");
    expect_read(6'h11, 8'hC3, "R9 mask untouched");
    expect_read(6'h0B, 8'hA5, "R9 ch1 data untouched");
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=0x0 expected=0x1");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    idle(5);
    rst = 1'b0;
    idle(3);
    t_reset();
    t_mode_sequence();
    t_command();
    t_channels();
    t_plain_regs();
    t_long_strobes();
    t_select_gate();
    t_holes();
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule